// File: doc/BRIEF.md
# Byte-Pipelined SPI Slave with Ready Handshake

This block is a slave-only SPI endpoint that exchanges one byte per frame with a host. The host pulls the block's own active-low select line, clocks eight bits with a clock that idles high, and releases select. While those eight command bits come in on MOSI, the block shifts out on MISO the response to the command of the previous frame. The response is therefore always one frame behind the command. MISO is reported as a data bit plus an output enable. Outside a frame the enable is low, so several slaves can share the MISO wire.

SCLK, select and MOSI are brought into a fast system clock through two-flop synchronizers, and all edge detection happens in that domain. A completed frame is handed to the parallel side as a one-cycle command strobe with the received byte. The block then holds its ready output low for a parameterized busy time, which stands in for acquisition. At the end of that time it captures the parallel response input, which is the byte it will return in the next frame. The ready output tells the host when it may begin a frame.

Incomplete frames are thrown away. A frame in which select stays low too long makes the block reset itself to idle.

Top module: `spi_ready_slave`

## Requirements
- R1: SPI mode: the clock idles high. The block samples MOSI on each rising SCLK edge and moves MISO to the next bit on each falling SCLK edge that follows a rising edge. Bits travel most significant first, and a frame carries 8 bits.
- R2: When select rises after exactly 8 rising SCLK edges, `cmd_valid_o` is high for exactly one system-clock cycle, and `cmd_data_o` carries the 8 received bits (the first bit received is bit 7).
- R3: The byte shifted out in a frame is the value `rsp_data_i` had at the last cycle of the busy period that followed the previous complete frame. Before any complete frame since reset, the byte is 0x00.
- R4: `miso_oe_o` is 1 within 3 system-clock cycles after select falls while ready is high. It is 0 within 3 cycles after select rises, and it stays 0 while select remains high. `miso_o` is 0 whenever `miso_oe_o` is 0.
- R5: After a complete frame, `ready_o` stays high for the cycle in which `miso_oe_o` drops, then stays low for exactly BUSY_CYCLES system-clock cycles, then returns high. It never falls while MISO is driven.
- R6: A frame that ends with fewer than 8 rising SCLK edges produces no command strobe, does not change the response byte of the next frame, and does not drop `ready_o`.
- R7: If select stays low for TIMEOUT_CYCLES system-clock cycles after a frame is accepted, the frame is abandoned. `miso_oe_o` and then `ready_o` go low, no command strobe is produced, and the response byte is cleared to 0x00. Once select is high again, `ready_o` returns high after BUSY_CYCLES cycles.
- R8: During reset and for exactly BUSY_CYCLES cycles after it, `ready_o`, `miso_oe_o` and `cmd_valid_o` are 0. After that, `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI clock from host, idles high |
| sel_n_i | input | 1 | Active-low select from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host, valid when enabled |
| miso_oe_o | output | 1 | MISO drive enable; 0 means high impedance |
| ready_o | output | 1 | 1 when the host may start a frame (the pin is released); 0 pulls it low |
| cmd_valid_o | output | 1 | One-cycle strobe for a received command |
| cmd_data_o | output | 8 | Last received command byte |
| rsp_data_i | input | 8 | Response byte to return in the next frame |

## Verification
On every cycle, the assertions check that MISO is never driven while ready is low, that the enable drops at least one cycle before ready falls, that MISO floats once select has been high for a few cycles, that a select held low far beyond the timeout leaves the block floating and not ready, and that the command strobe lasts a single cycle. Only the bench scenarios can show the byte contents. These are MSB-first sampling, the one-frame response lag across a sweep of all 256 command values, the 0x00 response after reset and after an abandoned frame, the exact busy length, and the discarding of short frames.

// File: rtl/spi_ready_pkg.sv
package spi_ready_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for select to fall, ready high
        ST_FRAME,  // select low, bits moving, MISO driven
        ST_DRAIN,  // MISO released, ready still high
        ST_BUSY,   // ready low, stand-in for acquisition
        ST_ABORT   // frame abandoned by timeout, wait for select high
    } ctl_state_e;

    // Synchronized pin view with edge events
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic sel_rise;
        logic sel_fall;
        logic sel_high;
        logic mosi;
    } pin_view_t;

    function automatic logic state_ready(input ctl_state_e s);
        return (s == ST_IDLE) || (s == ST_FRAME) || (s == ST_DRAIN);
    endfunction

endpackage

// File: rtl/spi_ready_sync.sv
module spi_ready_sync
    import spi_ready_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    input  logic      sel_n_i,
    input  logic      mosi_i,
    output pin_view_t view_o
);
    localparam int W = 3;
    localparam logic [W-1:0] IDLE_LVL = 3'b011; // {mosi, sel_n, sclk}

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] last_q;
    logic [W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_LVL;
            last_q <= IDLE_LVL;
        end else begin
            chain[0] <= {mosi_i, sel_n_i, sclk_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            last_q <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];

    always_comb begin
        view_o.sclk_rise = cur[0] & ~last_q[0];
        view_o.sclk_fall = ~cur[0] & last_q[0];
        view_o.sel_rise  = cur[1] & ~last_q[1];
        view_o.sel_fall  = ~cur[1] & last_q[1];
        view_o.sel_high  = cur[1];
        view_o.mosi      = cur[2];
    end

endmodule

// File: rtl/spi_ready_shifter.sv
module spi_ready_shifter
    import spi_ready_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  byte_t            load_byte_i,
    input  logic             active_i,
    input  pin_view_t        view_i,
    output logic             tx_bit_o,
    output byte_t            rx_byte_o,
    output logic [CNT_W-1:0] bit_cnt_o
);
    byte_t            tx_q;
    byte_t            rx_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            tx_q  <= load_byte_i;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (active_i) begin
            if (view_i.sclk_rise && cnt_q != CNT_W'(BYTE_W)) begin
                rx_q  <= {rx_q[BYTE_W-2:0], view_i.mosi};
                cnt_q <= cnt_q + 1'b1;
            end
            // the first falling edge only opens the frame; later ones advance
            if (view_i.sclk_fall && cnt_q != '0)
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign tx_bit_o  = tx_q[BYTE_W-1];
    assign rx_byte_o = rx_q;
    assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/spi_ready_ctrl.sv
module spi_ready_ctrl
    import spi_ready_pkg::*;
#(
    parameter int BUSY_CYCLES    = 1000,
    parameter int TIMEOUT_CYCLES = 750000
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_view_t        view_i,
    input  logic [CNT_W-1:0] bit_cnt_i,
    input  byte_t            rx_byte_i,
    input  byte_t            rsp_i,
    output ctl_state_e       state_o,
    output logic             load_o,
    output byte_t            rsp_q_o,
    output logic             cmd_valid_o,
    output byte_t            cmd_data_o
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    ctl_state_e st_q;
    logic [BW-1:0] busy_q;
    logic [TW-1:0] tmo_q;
    logic          pend_q;
    logic          abort_q;
    byte_t         rsp_q;
    byte_t         cmd_q;
    logic          strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_BUSY;
            busy_q   <= '0;
            tmo_q    <= '0;
            pend_q   <= 1'b0;
            abort_q  <= 1'b0;
            rsp_q    <= '0;
            cmd_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (view_i.sel_fall) begin
                        st_q  <= ST_FRAME;
                        tmo_q <= '0;
                    end
                end
                ST_FRAME: begin
                    if (view_i.sel_rise) begin
                        if (bit_cnt_i == CNT_W'(BYTE_W)) begin
                            cmd_q    <= rx_byte_i;
                            strobe_q <= 1'b1;
                            pend_q   <= 1'b1;
                            abort_q  <= 1'b0;
                            st_q     <= ST_DRAIN;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else if (tmo_q == TW'(TIMEOUT_CYCLES - 1)) begin
                        abort_q <= 1'b1;
                        pend_q  <= 1'b0;
                        rsp_q   <= '0;
                        st_q    <= ST_DRAIN;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    busy_q <= '0;
                    st_q   <= abort_q ? ST_ABORT : ST_BUSY;
                end
                ST_ABORT: begin
                    if (view_i.sel_high) begin
                        abort_q <= 1'b0;
                        busy_q  <= '0;
                        st_q    <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (busy_q == BW'(BUSY_CYCLES - 1)) begin
                        st_q <= ST_IDLE;
                        if (pend_q) rsp_q <= rsp_i;
                        pend_q <= 1'b0;
                    end else begin
                        busy_q <= busy_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o     = st_q;
    assign load_o      = (st_q == ST_IDLE) && view_i.sel_fall;
    assign rsp_q_o     = rsp_q;
    assign cmd_valid_o = strobe_q;
    assign cmd_data_o  = cmd_q;

endmodule

// File: rtl/spi_ready_slave.sv
module spi_ready_slave
    import spi_ready_pkg::*;
#(
    parameter int BUSY_CYCLES    = 1000,
    parameter int TIMEOUT_CYCLES = 750000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       sel_n_i,
    input  logic       mosi_i,
    output logic       miso_o,
    output logic       miso_oe_o,
    output logic       ready_o,
    output logic       cmd_valid_o,
    output logic [7:0] cmd_data_o,
    input  logic [7:0] rsp_data_i
);
    pin_view_t        view;
    ctl_state_e       state;
    logic             load;
    byte_t            rsp_q;
    byte_t            rx_byte;
    logic [CNT_W-1:0] bit_cnt;
    logic             tx_bit;

    spi_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .sel_n_i (sel_n_i),
        .mosi_i  (mosi_i),
        .view_o  (view)
    );

    spi_ready_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .load_byte_i (rsp_q),
        .active_i    (state == ST_FRAME),
        .view_i      (view),
        .tx_bit_o    (tx_bit),
        .rx_byte_o   (rx_byte),
        .bit_cnt_o   (bit_cnt)
    );

    spi_ready_ctrl #(
        .BUSY_CYCLES    (BUSY_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .view_i      (view),
        .bit_cnt_i   (bit_cnt),
        .rx_byte_i   (rx_byte),
        .rsp_i       (rsp_data_i),
        .state_o     (state),
        .load_o      (load),
        .rsp_q_o     (rsp_q),
        .cmd_valid_o (cmd_valid_o),
        .cmd_data_o  (cmd_data_o)
    );

    assign miso_oe_o = (state == ST_FRAME);
    assign miso_o    = miso_oe_o & tx_bit;
    assign ready_o   = state_ready(state);

endmodule

// File: rtl/spi_ready_slave_chk.sv
module spi_ready_slave_chk #(
    parameter int TIMEOUT_CYCLES = 750000
) (
    input logic clk,
    input logic rst,
    input logic sel_n_i,
    input logic miso_oe_o,
    input logic ready_o,
    input logic cmd_valid_o
);
    int unsigned hi_run;
    int unsigned lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= 0;
            lo_run <= 0;
        end else if (sel_n_i) begin
            lo_run <= 0;
            if (hi_run < 1000) hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
            if (lo_run < TIMEOUT_CYCLES + 1000) lo_run <= lo_run + 1;
        end
    end

    // R5
    busy_float_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> !miso_oe_o);

    // R5
    release_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(!miso_oe_o));

    // R4
    deselect_float_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_run >= 4) |-> !miso_oe_o);

    // R7
    timeout_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_run > TIMEOUT_CYCLES + 8) |-> (!miso_oe_o && !ready_o));

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

endmodule

bind spi_ready_slave spi_ready_slave_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_n_i     (sel_n_i),
    .miso_oe_o   (miso_oe_o),
    .ready_o     (ready_o),
    .cmd_valid_o (cmd_valid_o)
);

// File: tb/spi_ready_slave_tb.sv
module spi_ready_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 6;
    localparam int BUSY       = 20;
    localparam int TMO        = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       sel_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso_o, miso_oe_o, ready_o, cmd_valid_o;
    logic [7:0] cmd_data_o, rsp_data_i;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    logic [7:0] vdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ready_slave #(.BUSY_CYCLES(BUSY), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sel_n_i(sel_n), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ready_o(ready_o),
        .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .rsp_data_i(rsp_data_i)
    );

    function automatic logic [7:0] rsp_of(input logic [7:0] c);
        return {c[3:0], c[7:4]} ^ 8'hA5;
    endfunction

    assign rsp_data_i = rsp_of(cmd_data_o);

    always @(negedge clk) begin
        if (!rst && cmd_valid_o) begin
            vcnt  = vcnt + 1;
            vdata = cmd_data_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!ready_o && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic shift_frame(input logic [7:0] cmd, input int nbits,
                               output logic [7:0] got);
        got = 8'h00;
        sel_n = 1'b0;
        idle(3);
        check(miso_oe_o == 1'b1, "R4", "miso driven after select", int'(miso_oe_o), 1);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = cmd[7-i];
            idle(HALF_SCLK);
            got[7-i] = miso_o;
            sclk = 1'b1;
            idle(HALF_SCLK);
        end
        idle(2);
        sel_n = 1'b1;
        idle(3);
        check(miso_oe_o == 1'b0 && miso_o == 1'b0, "R4", "miso floats after select",
              int'({miso_oe_o, miso_o}), 0);
    endtask

    task automatic full_frame(input logic [7:0] cmd, input logic [7:0] exp,
                              input string req);
        logic [7:0] got;
        int v0;
        int n;
        wait_ready();
        v0 = vcnt;
        shift_frame(cmd, 8, got);
        check(got == exp, req, "response byte", int'(got), int'(exp));
        check(ready_o == 1'b1, "R5", "ready high while MISO released", int'(ready_o), 1);
        idle(1);
        n = 0;
        while (!ready_o && n < 1000) begin
            n++;
            idle(1);
        end
        check(n == BUSY, "R5", "busy length", n, BUSY);
        check(vcnt == v0 + 1, "R2", "strobe count", vcnt - v0, 1);
        check(vdata == cmd, "R2", "command byte", int'(vdata), int'(cmd));
    endtask

    task automatic short_frame(input logic [7:0] cmd, input int nbits,
                               input logic [7:0] exp);
        logic [7:0] got;
        int v0;
        bit stayed;
        wait_ready();
        v0 = vcnt;
        shift_frame(cmd, nbits, got);
        if (nbits > 0)
            check((got >> (8 - nbits)) == (exp >> (8 - nbits)), "R1",
                  "partial bits MSB first", int'(got >> (8 - nbits)),
                  int'(exp >> (8 - nbits)));
        stayed = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (!ready_o) stayed = 1'b0;
            idle(1);
        end
        check(stayed, "R6", "ready kept high after short frame", int'(stayed), 1);
        check(vcnt == v0, "R6", "no strobe for short frame", vcnt - v0, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] exp;
        int n;
        int v0;

        idle(6);
        // R8: reset state
        check(ready_o == 1'b0, "R8", "ready in reset", int'(ready_o), 0);
        check(miso_oe_o == 1'b0, "R8", "miso enable in reset", int'(miso_oe_o), 0);
        check(cmd_valid_o == 1'b0, "R8", "strobe in reset", int'(cmd_valid_o), 0);
        rst = 1'b0;
        n = 0;
        while (!ready_o && n < 1000) begin
            n++;
            idle(1);
        end
        check(n == BUSY, "R8", "startup busy length", n, BUSY);

        // R1 R3: sweep all command values, response lags one frame, first is 0x00
        exp = 8'h00;
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cmd;
            cmd = 8'(c * 37 + 11);
            full_frame(cmd, exp, "R3");
            exp = rsp_of(cmd);
        end

        // R6: short frames leave the pipeline alone
        short_frame(8'hF0, 3, exp);
        short_frame(8'h0F, 7, exp);
        short_frame(8'h55, 0, exp);
        full_frame(8'h81, exp, "R6");
        exp = rsp_of(8'h81);

        // R7: select held low past the timeout
        wait_ready();
        v0 = vcnt;
        sel_n = 1'b0;
        sclk = 1'b0;
        idle(HALF_SCLK);
        sclk = 1'b1;
        idle(TMO + 20);
        check(miso_oe_o == 1'b0, "R7", "miso floats after timeout", int'(miso_oe_o), 0);
        check(ready_o == 1'b0, "R7", "ready low after timeout", int'(ready_o), 0);
        sel_n = 1'b1;
        wait_ready();
        check(ready_o == 1'b1, "R7", "ready back after abort", int'(ready_o), 1);
        check(vcnt == v0, "R7", "no strobe on abort", vcnt - v0, 0);
        full_frame(8'h42, 8'h00, "R7");
        exp = rsp_of(8'h42);
        full_frame(8'h99, exp, "R1");

        summary();
        $finish;
    end

endmodule